// File: doc/BRIEF.md
# Differential Pair Output Code Formatter

This block produces the final 10-bit result word from a signed conversion difference. The difference comes in already scaled so that one step equals one unipolar code step, that is the reference divided by 1024. The block decides which number format applies to the conversion and clamps the value to the range of that format. It then registers the code together with a one-cycle valid pulse.

Channels are grouped in pairs: channel 2k and channel 2k+1 form pair k. Each pair has one bit in a unipolar mode register and one bit in a bipolar mode register. A small configuration write port updates these registers, and a 2-bit selector picks which register a write targets. A conversion that arrives with its differential flag low is single-ended and always takes the unipolar format. A differential conversion takes the two's complement format only when its pair's bipolar bit is set. Otherwise it takes the unipolar format.

Top module: `pair_code_formatter`

## Requirements
- R1: After reset `code_valid` and `code_out` are zero and both mode registers are cleared, so every channel formats as unipolar.
- R2: `code_valid` is high for exactly the cycle after each cycle in which `conv_valid` is high. `code_out` changes only in that cycle and holds its value otherwise.
- R3: In unipolar format a difference from 0 to 1023 gives a straight binary code equal to the difference.
- R4: In unipolar format any negative difference gives code 0x000.
- R5: In unipolar format a difference of 1024 or more gives code 0x3FF.
- R6: In bipolar format a difference from -512 to 511 gives its 10-bit two's complement value (for example -1 gives 0x3FF and -100 gives 0x39C).
- R7: In bipolar format a difference above 511 gives 0x1FF and a difference below -512 gives 0x200.
- R8: A conversion with `conv_diff` low is formatted as unipolar even when the bipolar bit of its pair is set.
- R9: A write with `cfg_sel` = 2'b10 loads the unipolar register and a write with `cfg_sel` = 2'b11 loads the bipolar register, both from `cfg_data`, where bit k belongs to pair k. Writes with `cfg_sel[1]` = 0 leave both registers unchanged.
- R10: When a write sets a pair's bit in one register, that pair's bit in the other register is cleared, so the most recent write decides the pair's mode.
- R11: A conversion presented in the same cycle as a configuration write is formatted with the mode held before that write.
- R12: The pair of a conversion is `conv_chan` shifted right by one. Pairs keep independent modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target register select (2'b10 unipolar, 2'b11 bipolar) |
| cfg_data | input | NUM_CH/2 | One mode bit per channel pair |
| conv_valid | input | 1 | Conversion difference is valid this cycle |
| conv_chan | input | $clog2(NUM_CH) | Channel index of the conversion |
| conv_diff | input | 1 | High for a differential conversion, low for single-ended |
| conv_delta | input | DELTA_W | Signed difference in unipolar LSB units |
| code_out | output | CODE_W | Registered output code |
| code_valid | output | 1 | One-cycle strobe marking a new code |

## Verification
The two functions that can meet in one cycle are a mode-register write and a conversion on the pair being reconfigured. The bench issues a bipolar write for a pair in the same cycle as a negative differential conversion on that pair. The result must be the unipolar clamp to zero, taken from the mode held before the write. A second conversion one cycle later must come out in two's complement, which shows that the write did take effect.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  localparam logic [1:0] CFG_SEL_UNI = 2'b10;
  localparam logic [1:0] CFG_SEL_BIP = 2'b11;

  typedef enum logic {
    FMT_STRAIGHT = 1'b0,
    FMT_TWOS     = 1'b1
  } code_fmt_e;
endpackage

// File: rtl/pcf_mode_regs.sv
module pcf_mode_regs #(
  parameter int NUM_PAIRS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [NUM_PAIRS-1:0] cfg_data,
  output logic [NUM_PAIRS-1:0] bip_mode
);
  import pcf_pkg::*;

  logic [NUM_PAIRS-1:0] uni_mode;
  logic wr_uni, wr_bip;

  assign wr_uni = cfg_we && (cfg_sel == CFG_SEL_UNI);
  assign wr_bip = cfg_we && (cfg_sel == CFG_SEL_BIP);

  for (genvar gp = 0; gp < NUM_PAIRS; gp++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        uni_mode[gp] <= 1'b0;
        bip_mode[gp] <= 1'b0;
      end else if (wr_uni) begin
        uni_mode[gp] <= cfg_data[gp];
        if (cfg_data[gp]) bip_mode[gp] <= 1'b0;
      end else if (wr_bip) begin
        bip_mode[gp] <= cfg_data[gp];
        if (cfg_data[gp]) uni_mode[gp] <= 1'b0;
      end
    end
  end

  // R10: a pair never holds both modes at once
  a_r10_modes_exclusive: assert property (@(posedge clk) disable iff (rst)
    (uni_mode & bip_mode) == '0);

  // R9: a write whose selector has bit 1 low changes nothing
  a_r9_bad_sel_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_sel[1]) |=> ($stable(uni_mode) && $stable(bip_mode)));

  // R1: reset clears both registers
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (uni_mode == '0 && bip_mode == '0));
endmodule

// File: rtl/pcf_range_clamp.sv
module pcf_range_clamp #(
  parameter int DELTA_W = 12,
  parameter int CODE_W  = 10
) (
  input  pcf_pkg::code_fmt_e         fmt,
  input  logic signed [DELTA_W-1:0]  delta,
  output logic [CODE_W-1:0]          code
);
  import pcf_pkg::*;

  localparam logic signed [DELTA_W-1:0] UNI_HI = DELTA_W'((1 << CODE_W) - 1);
  localparam logic signed [DELTA_W-1:0] BIP_HI = DELTA_W'((1 << (CODE_W-1)) - 1);
  localparam logic signed [DELTA_W-1:0] BIP_LO = -DELTA_W'(1 << (CODE_W-1));

  always_comb begin
    if (fmt == FMT_TWOS) begin
      if (delta > BIP_HI)      code = {1'b0, {(CODE_W-1){1'b1}}};
      else if (delta < BIP_LO) code = {1'b1, {(CODE_W-1){1'b0}}};
      else                     code = delta[CODE_W-1:0];
    end else begin
      if (delta[DELTA_W-1])    code = '0;
      else if (delta > UNI_HI) code = '1;
      else                     code = delta[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/pair_code_formatter.sv
module pair_code_formatter #(
  parameter int NUM_CH  = 16,
  parameter int DELTA_W = 12,
  parameter int CODE_W  = 10,
  localparam int NUM_PAIRS = NUM_CH / 2,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic [NUM_PAIRS-1:0]      cfg_data,
  input  logic                      conv_valid,
  input  logic [CH_W-1:0]           conv_chan,
  input  logic                      conv_diff,
  input  logic signed [DELTA_W-1:0] conv_delta,
  output logic [CODE_W-1:0]         code_out,
  output logic                      code_valid
);
  import pcf_pkg::*;

  logic [NUM_PAIRS-1:0] bip_mode;
  logic [CH_W-2:0]      pair_idx;
  code_fmt_e            fmt;
  logic [CODE_W-1:0]    code_nxt;

  pcf_mode_regs #(.NUM_PAIRS(NUM_PAIRS)) u_modes (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .bip_mode(bip_mode)
  );

  assign pair_idx = conv_chan[CH_W-1:1];
  assign fmt = (conv_diff && bip_mode[pair_idx]) ? FMT_TWOS : FMT_STRAIGHT;

  pcf_range_clamp #(.DELTA_W(DELTA_W), .CODE_W(CODE_W)) u_clamp (
    .fmt(fmt), .delta(conv_delta), .code(code_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_out   <= '0;
      code_valid <= 1'b0;
    end else begin
      code_valid <= conv_valid;
      if (conv_valid) code_out <= code_nxt;
    end
  end

  // R2: strobe follows request by one cycle, and only then
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    conv_valid |=> code_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !conv_valid |=> (!code_valid && $stable(code_out)));

  // R4: unipolar negative input yields zero
  a_r4_neg_zero: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && fmt == FMT_STRAIGHT && conv_delta < 0) |=> code_out == '0);

  // R8: single-ended never produces a two's complement negative code
  a_r8_single_unipolar: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && !conv_diff && conv_delta < 0) |=> code_out == '0);

  // R7: bipolar over-range saturates positive
  a_r7_bip_high: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && fmt == FMT_TWOS && conv_delta > 511) |=> code_out == 10'h1FF);
endmodule

// File: tb/pair_code_formatter_tb_top.sv
module pair_code_formatter_tb_top;
  localparam int N_VEC = 19;

  logic clk = 1'b0;
  logic rst;
  logic cfg_we;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_data;
  logic conv_valid;
  logic [3:0] conv_chan;
  logic conv_diff;
  logic signed [11:0] conv_delta;
  logic [9:0] code_out;
  logic code_valid;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pair_code_formatter dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .conv_valid(conv_valid), .conv_chan(conv_chan),
    .conv_diff(conv_diff), .conv_delta(conv_delta),
    .code_out(code_out), .code_valid(code_valid)
  );

  // {req[3:0], diff, chan[3:0], delta[11:0], expected[9:0]}
  // Setup before the walk: pair0 unipolar, pair1 bipolar, pair2 untouched.
  localparam logic [30:0] VEC [N_VEC] = '{
    {4'd3,  1'b1, 4'd0,  12'sd0,     10'h000},  // R3
    {4'd3,  1'b1, 4'd1,  12'sd513,   10'h201},  // R3
    {4'd3,  1'b1, 4'd0,  12'sd1023,  10'h3FF},  // R3
    {4'd5,  1'b1, 4'd0,  12'sd1024,  10'h3FF},  // R5
    {4'd5,  1'b1, 4'd0,  12'sd2047,  10'h3FF},  // R5
    {4'd4,  1'b1, 4'd0, -12'sd1,     10'h000},  // R4
    {4'd4,  1'b1, 4'd1, -12'sd2048,  10'h000},  // R4
    {4'd6,  1'b1, 4'd2,  12'sd0,     10'h000},  // R6
    {4'd6,  1'b1, 4'd2,  12'sd511,   10'h1FF},  // R6
    {4'd6,  1'b1, 4'd2, -12'sd512,   10'h200},  // R6
    {4'd6,  1'b1, 4'd3, -12'sd1,     10'h3FF},  // R6
    {4'd6,  1'b1, 4'd2, -12'sd100,   10'h39C},  // R6
    {4'd7,  1'b1, 4'd2,  12'sd512,   10'h1FF},  // R7
    {4'd7,  1'b1, 4'd3, -12'sd513,   10'h200},  // R7
    {4'd8,  1'b0, 4'd3, -12'sd5,     10'h000},  // R8
    {4'd8,  1'b0, 4'd2,  12'sd700,   10'h2BC},  // R8
    {4'd12, 1'b1, 4'd4, -12'sd3,     10'h000},  // R12
    {4'd12, 1'b1, 4'd5,  12'sd1500,  10'h3FF},  // R12
    {4'd12, 1'b1, 4'd3,  12'sd100,   10'h064}   // R12
  };

  function automatic string tag_of(input logic [3:0] r);
    case (r)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", tag, act, exp_v);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one conversion, then sample the registered result one clock later
  task automatic convert(input string tag, input logic d, input logic [3:0] ch,
                         input logic signed [11:0] dl, input logic [9:0] exp_v);
    @(negedge clk);
    conv_valid = 1'b1; conv_diff = d; conv_chan = ch; conv_delta = dl;
    @(negedge clk);
    check(tag, {9'd0, code_valid}, 10'd1);
    check(tag, code_out, exp_v);
    conv_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = 2'b00; cfg_data = '0;
    conv_valid = 1'b0; conv_chan = '0; conv_diff = 1'b0; conv_delta = '0;
    repeat (3) @(negedge clk);
    // R1: reset outputs
    check("R1", {9'd0, code_valid}, 10'd0);
    check("R1", code_out, 10'h000);
    rst = 1'b0;
    // R1: modes cleared, differential negative on pair1 clamps to zero
    convert("R1", 1'b1, 4'd2, -12'sd1, 10'h000);
    // R2: no strobe and held output on an idle cycle
    @(negedge clk);
    check("R2", {9'd0, code_valid}, 10'd0);
    check("R2", code_out, 10'h000);

    cfg_write(2'b10, 8'b0000_0001);
    cfg_write(2'b11, 8'b0000_0010);
    for (int i = 0; i < N_VEC; i++) begin
      convert(tag_of(VEC[i][30:27]), VEC[i][26], VEC[i][25:22],
              VEC[i][21:10], VEC[i][9:0]);
    end

    // R9: selectors 00 and 01 are ignored
    cfg_write(2'b00, 8'hFF);
    cfg_write(2'b01, 8'hFF);
    convert("R9", 1'b1, 4'd4, -12'sd3, 10'h000);
    convert("R9", 1'b1, 4'd2, -12'sd3, 10'h3FD);

    // R10: latest write wins per pair
    cfg_write(2'b11, 8'b0000_0011);
    convert("R10", 1'b1, 4'd0, -12'sd5, 10'h3FB);
    cfg_write(2'b10, 8'b0000_0001);
    convert("R10", 1'b1, 4'd0, -12'sd5, 10'h000);
    convert("R10", 1'b1, 4'd2, -12'sd5, 10'h3FB);

    // R11: write and conversion in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'b11; cfg_data = 8'b0000_0110;
    conv_valid = 1'b1; conv_diff = 1'b1; conv_chan = 4'd4; conv_delta = -12'sd3;
    @(negedge clk);
    cfg_we = 1'b0; conv_delta = -12'sd3;
    check("R11", code_out, 10'h000);
    @(negedge clk);
    check("R11", code_out, 10'h3FD);
    conv_valid = 1'b0;
    @(negedge clk);
    check("R2", {9'd0, code_valid}, 10'd0);

    // R1: reset mid-run clears the bipolar setting
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    convert("R1", 1'b1, 4'd4, -12'sd3, 10'h000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule